// File: doc/BRIEF.md
# Sticky Event Status and Interrupt Register Pair

This block holds the control and status registers of a cell interface module. It sits on a simple 16-bit register bus that carries an address, a write strobe, write data and combinational read data. Three single-cycle event pulses come from the surrounding module: data FIFO overrun, internal FIFO overrun and data cell received. The block captures each pulse into a sticky status bit, which stays set until software writes a one to that bit.

Each status bit has its own interrupt enable in the control register. A registered service output tells the top-level interrupt mux that an enabled status bit is set. The top bit of the status word summarises all three status bits and ignores the enables. A test bit in the control register forces all three events on every cycle while it is high.

Top module: `evtStatusRegs`

## Requirements
- R1: After reset, the control and status registers both read 0000h and `serviceOut` is low.
- R2: The control register at address CTRL_ADDR (default 0) holds four bits: bit 0 is the cell-received enable, bit 1 the internal-overrun enable, bit 2 the FIFO-overrun enable, bit 3 the test bit. All other bits read as zero whatever was written.
- R3: The status register at address STAT_ADDR (default 2) shows FIFO overrun at bit 12, internal overrun at bit 11 and cell received at bit 10. Bits 9:0 and 14:13 always read zero.
- R4: An event pulse high at a clock edge sets its status bit, which reads one from that edge on. The bit stays set without further events.
- R5: Writing the status address with a one in a status bit position clears that bit. A zero in that position leaves the bit unchanged.
- R6: If an event and a clearing write hit the same status bit at the same edge, the bit stays set.
- R7: Status bit 15 reads one exactly when any of the three status bits is one, regardless of the enables.
- R8: `serviceOut` is high in the cycle after a cycle in which some status bit and its enable were both one, and low otherwise.
- R9: While the test bit is one, all three status bits are set at every edge and cannot be cleared.
- R10: Reads of any other address return zero. A write to the status address leaves the control register unchanged. A write to the control address clears no status bit. A write to any other address changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | ADDR_W | Register address |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data, combinational from address and state |
| evtFifoOvr | input | 1 | Data FIFO overrun event pulse |
| evtIntOvr | input | 1 | Internal FIFO overrun event pulse |
| evtCellRx | input | 1 | Data cell received event pulse |
| serviceOut | output | 1 | Registered service request to the top-level interrupt mux |

## Verification
Register writes, clears and event captures take effect at the edge where they are presented, so read data reflects them from that edge onward. `serviceOut` adds one more register and lags the status by exactly one cycle. The bench drives inputs between edges and applies the same per-edge updates in a behavioural model. It samples both outputs at the falling edge, half a period after each rising edge, so every due value is settled when it is compared.

// File: rtl/evtRegsPkg.sv
package evtRegsPkg;
  localparam int DATA_W   = 16;
  localparam int NUM_EVT  = 3;
  localparam int STAT_LSB = 10;
  localparam int SUM_BIT  = 15;
  localparam int TEST_BIT = 3;

  typedef struct packed {
    logic selCtrl;
    logic selStat;
    logic ctrlWr;
    logic statClr;
  } regStrb_t;
endpackage

// File: rtl/evtRegsCtrl.sv
module evtRegsCtrl
  import evtRegsPkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 2
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrb_t          strb
);
  localparam logic [ADDR_W-1:0] CtrlA = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] StatA = ADDR_W'(STAT_ADDR);

  always_comb begin
    strb.selCtrl = (regAddr == CtrlA);
    strb.selStat = (regAddr == StatA);
    strb.ctrlWr  = regWrEn && strb.selCtrl;
    strb.statClr = regWrEn && strb.selStat;
  end

  always_comb begin
    AST_STRB_EXCL: assert (!(strb.ctrlWr && strb.statClr)); // R10
  end
endmodule

// File: rtl/evtRegsDatapath.sv
module evtRegsDatapath
  import evtRegsPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  regStrb_t           strb,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic [NUM_EVT-1:0] evtIn,
  output logic [DATA_W-1:0]  regRdData,
  output logic               serviceOut
);
  localparam int CTRL_W = TEST_BIT + 1;

  logic [CTRL_W-1:0]  ctrlBits;
  logic [NUM_EVT-1:0] statBits;
  logic [NUM_EVT-1:0] ieBits;
  logic [NUM_EVT-1:0] evtEff;
  logic               testOn;

  assign ieBits = ctrlBits[NUM_EVT-1:0];
  assign testOn = ctrlBits[TEST_BIT];
  assign evtEff = evtIn | {NUM_EVT{testOn}};

  always_ff @(posedge clk) begin
    if (!rstN) ctrlBits <= '0;
    else if (strb.ctrlWr) ctrlBits <= regWrData[CTRL_W-1:0];
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : gStat
    always_ff @(posedge clk) begin
      if (!rstN) statBits[i] <= 1'b0;
      else if (evtEff[i]) statBits[i] <= 1'b1;
      else if (strb.statClr && regWrData[STAT_LSB+i]) statBits[i] <= 1'b0;
    end

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rstN)
      evtIn[i] |=> statBits[i]); // R4
    AST_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      (statBits[i] && !(strb.statClr && regWrData[STAT_LSB+i])) |=> statBits[i]); // R5
  end

  always_ff @(posedge clk) begin
    if (!rstN) serviceOut <= 1'b0;
    else serviceOut <= |(statBits & ieBits);
  end

  always_comb begin
    regRdData = '0;
    if (strb.selCtrl) regRdData[CTRL_W-1:0] = ctrlBits;
    else if (strb.selStat) begin
      regRdData[STAT_LSB +: NUM_EVT] = statBits;
      regRdData[SUM_BIT]             = |statBits;
    end
  end

  AST_TEST_FORCE: assert property (@(posedge clk) disable iff (!rstN)
    testOn |=> (&statBits)); // R9
  AST_SVC_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (statBits == '0) |=> !serviceOut); // R8
  AST_SVC_FIRE: assert property (@(posedge clk) disable iff (!rstN)
    ((statBits & ieBits) != '0) |=> serviceOut); // R8
  always_comb begin
    if (strb.selStat)
      AST_RSVD_ZERO: assert (regRdData[STAT_LSB-1:0] == '0 &&
                             regRdData[SUM_BIT-1:STAT_LSB+NUM_EVT] == '0); // R3
  end
endmodule

// File: rtl/evtStatusRegs.sv
module evtStatusRegs
  import evtRegsPkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int CTRL_ADDR = 0,
  parameter int STAT_ADDR = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [15:0]       regWrData,
  output logic [15:0]       regRdData,
  input  logic              evtFifoOvr,
  input  logic              evtIntOvr,
  input  logic              evtCellRx,
  output logic              serviceOut
);
  regStrb_t strb;

  evtRegsCtrl #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
  ) ctrl_i (
    .regAddr(regAddr), .regWrEn(regWrEn), .strb(strb)
  );

  evtRegsDatapath dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData),
    .evtIn({evtFifoOvr, evtIntOvr, evtCellRx}),
    .regRdData(regRdData), .serviceOut(serviceOut)
  );
endmodule

// File: tb/evtStatusRegs_tb.sv
module evtStatusRegs_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        evtFifoOvr = 1'b0, evtIntOvr = 1'b0, evtCellRx = 1'b0;
  logic        serviceOut;

  int vecCnt = 0;
  int errCnt = 0;

  // behavioural reference state
  int ctrlM = 0;
  int statM = 0;  // bit0 cellRx, bit1 intOvr, bit2 fifoOvr
  bit svcM = 0;

  always #10 clk = ~clk;

  evtStatusRegs dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData),
    .evtFifoOvr(evtFifoOvr), .evtIntOvr(evtIntOvr), .evtCellRx(evtCellRx),
    .serviceOut(serviceOut)
  );

  function automatic logic [15:0] expRead(input logic [3:0] a);
    if (a == 4'd0) return 16'(ctrlM & 15);
    if (a == 4'd2) return 16'(((statM != 0) ? 32'h8000 : 0) | (statM << 10));
    return 16'h0000;
  endfunction

  task automatic compare(input string tag);
    logic [15:0] e;
    e = expRead(regAddr);
    vecCnt++;
    if (regRdData !== e || serviceOut !== svcM) begin
      errCnt++;
      $display("FAIL %s: rd=%h svc=%b expected rd=%h svc=%b", tag, regRdData,
               serviceOut, e, svcM);
    end
  endtask

  // present inputs, take one edge, update model, compare at falling edge
  task automatic step(input logic [3:0] a, input bit we, input logic [15:0] wd,
                      input logic [2:0] ev, input string tag);
    int ev2, clr;
    regAddr = a; regWrEn = we; regWrData = wd;
    {evtFifoOvr, evtIntOvr, evtCellRx} = ev;
    @(posedge clk);
    #1;
    svcM = ((statM & ctrlM & 7) != 0);
    ev2 = int'(ev) | (((ctrlM >> 3) & 1) != 0 ? 7 : 0);
    clr = (we && a == 4'd2) ? ((wd >> 10) & 7) : 0;
    statM = (statM & ~clr) | ev2;
    if (we && a == 4'd0) ctrlM = wd & 15;
    @(negedge clk);
    regWrEn = 1'b0; {evtFifoOvr, evtIntOvr, evtCellRx} = 3'b000;
    compare(tag);
  endtask

  initial begin
    #2000000;
    errCnt++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    regAddr = 4'd0; #1 compare("R1 ctrl reset");
    regAddr = 4'd2; #1 compare("R1 stat reset");
    // R2 control bits and reserved readback
    step(4'd0, 1, 16'hFFF5, 3'b000, "R2 write ctrl");
    step(4'd0, 0, 16'h0000, 3'b000, "R2 read ctrl");
    step(4'd0, 1, 16'h0000, 3'b000, "R2 clear ctrl");
    // R4 single events, R3 positions, R7 summary with enables off
    step(4'd2, 0, 16'h0000, 3'b001, "R4 cellRx");
    step(4'd2, 0, 16'h0000, 3'b000, "R7 summary no enable");
    step(4'd2, 0, 16'h0000, 3'b010, "R3 intOvr");
    step(4'd2, 0, 16'h0000, 3'b100, "R3 fifoOvr");
    step(4'd2, 0, 16'h0000, 3'b000, "R4 sticky");
    // R5 clear with zeros then with one bit
    step(4'd2, 1, 16'h0000, 3'b000, "R5 zero write");
    step(4'd2, 1, 16'h0800, 3'b000, "R5 clear intOvr");
    // R6 event and clear collide
    step(4'd2, 1, 16'h1000, 3'b100, "R6 collide");
    // R10 other address reads zero, control write keeps status
    step(4'd5, 1, 16'hFFFF, 3'b000, "R10 other addr");
    step(4'd0, 1, 16'h1C00, 3'b000, "R10 ctrl write no clear");
    step(4'd2, 1, 16'h000F, 3'b000, "R10 stat write keeps ctrl");
    step(4'd0, 0, 16'h0000, 3'b000, "R10 ctrl unchanged");
    // R8 service output
    step(4'd0, 1, 16'h0004, 3'b000, "R8 enable fifo");
    step(4'd2, 0, 16'h0000, 3'b000, "R8 service high");
    step(4'd2, 1, 16'h1400, 3'b000, "R8 clear");
    step(4'd2, 0, 16'h0000, 3'b000, "R8 service falls");
    step(4'd2, 0, 16'h0000, 3'b000, "R8 service low");
    // R9 test force
    step(4'd0, 1, 16'h0008, 3'b000, "R9 test on");
    step(4'd2, 1, 16'h1C00, 3'b000, "R9 clear blocked");
    step(4'd2, 0, 16'h0000, 3'b000, "R9 forced");
    step(4'd0, 1, 16'h0000, 3'b000, "R9 test off");
    step(4'd2, 1, 16'h1C00, 3'b000, "R9 clear after");
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [3:0] a;
      logic [15:0] wd;
      a = 4'($urandom_range(0, 3));
      wd = 16'($urandom);
      if ($urandom_range(0, 3) != 0) wd[3] = 1'b0;
      step(a, 1'($urandom_range(0, 1)), wd, 3'($urandom_range(0, 7) & $urandom_range(0, 7)),
           "R10 random");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule